// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, once per incoming frame, whether the frame should be kept or dropped. The decision depends only on the 48-bit destination address, the frame length and a small set of control words. The filter compares the destination against two programmable unicast station addresses and against the all-ones broadcast address. Each of these comparisons has its own enable. A 64-entry hashed group table can also pass the frame. The table is indexed by folding the address into six bits with XOR, and it works as a one-hash Bloom-style membership test for multicast groups.

The receive path presents the destination address, the length and the current control words, and raises a one-cycle frame-start strobe. The block samples all of these on that edge. On the following cycle it raises a one-cycle decision-valid pulse together with the accept flag. Control words are used only when they are sampled, so a change made between frames applies to the next frame that is started.

Top module: `rxf_top`

## Requirements
- R1: After reset, and until the first frame-start strobe, `dec_valid` and `dec_accept` are both low.
- R2: Every cycle with `frame_start` high is followed, on the next cycle, by exactly one cycle with `dec_valid` high. `dec_valid` is never high in any other cycle.
- R3: When `rx_ctrl` bit 0 is set, a destination equal to station address 0 is accepted. Station address 0 is formed as {`ia0_hi`[15:0], `ia0_lo`}, with address byte 0 in bits 7:0 and byte 5 in bits 47:40.
- R4: When `rx_ctrl` bit 1 is set, a destination equal to station address 1 ({`ia1_hi`[15:0], `ia1_lo`}) is accepted. A station address whose enable bit is clear has no effect on the decision.
- R5: When `rx_ctrl` bit 3 is set, the all-ones destination is accepted.
- R6: The group index is the XOR of the eight 6-bit slices of the destination (bits 5:0, 11:6, through 47:42). An index below 32 selects bit `idx` of `grp_lo`. An index of 32 or more selects bit `idx-32` of `grp_hi`. A set bit is a group hit.
- R7: When `rx_ctrl` bit 2 is clear, the group table is consulted only when destination bit 0 (the group bit of byte 0) is set. When `rx_ctrl` bit 2 is set, the table is consulted for every destination.
- R8: A frame with `frame_len` below 12 is dropped whatever the address matches are.
- R9: A frame of legal length that meets none of R3, R4, R5 or R6/R7 is dropped.
- R10: `dec_accept` is high only in a cycle in which `dec_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe; samples all other inputs |
| dest_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_len | input | 16 | Frame length in bytes |
| rx_ctrl | input | 4 | Bit0 station 0 enable, bit1 station 1 enable, bit2 group table for all, bit3 broadcast enable |
| ia0_lo | input | 32 | Station address 0, bytes 0..3 |
| ia0_hi | input | 32 | Station address 0, bytes 4..5 in bits 15:0 |
| ia1_lo | input | 32 | Station address 1, bytes 0..3 |
| ia1_hi | input | 32 | Station address 1, bytes 4..5 in bits 15:0 |
| grp_lo | input | 32 | Group table entries 0..31 |
| grp_hi | input | 32 | Group table entries 32..63 |
| dec_valid | output | 1 | Decision pulse, one cycle after frame_start |
| dec_accept | output | 1 | Keep the frame (qualified by dec_valid) |

## Verification
The block holds no state across frames, so a wrong internal result shows up at the ports one cycle after the strobe, in the same pulse that carries the decision. A mis-wired hash slice or a swapped table half flips the decision only for addresses whose index lands on a programmed bit. For that reason the stimulus places group hits in both table halves and includes a unicast address that hashes onto a set bit. A bad valid register shows up either as a missing pulse or as a pulse that has no strobe before it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_W  = 48;
  localparam int HASH_W  = 6;
  localparam int SLICES  = ADDR_W / HASH_W;
  localparam int TBL_N   = 1 << HASH_W;
  localparam int CTL_W   = 4;
  localparam int CTL_IA0 = 0;
  localparam int CTL_GRP_ALL = 2;
  localparam int CTL_BCAST   = 3;

  typedef struct packed {
    logic ia;
    logic bcast;
    logic grp;
  } rxf_hits_t;

  function automatic logic [HASH_W-1:0] rxf_fold(input logic [ADDR_W-1:0] a);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int i = 0; i < SLICES; i++) h ^= a[i*HASH_W +: HASH_W];
    return h;
  endfunction
endpackage

// File: rtl/rxf_ia_match.sv
module rxf_ia_match
  import rxf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] hi,
  input  logic              en,
  output logic              hit
);
  localparam int HI_USED = ADDR_W - WORD_W;
  logic [ADDR_W-1:0] station;
  assign station = {hi[HI_USED-1:0], lo};
  assign hit = en && (station == addr);
endmodule

// File: rtl/rxf_grp_lookup.sv
module rxf_grp_lookup
  import rxf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] tbl_lo,
  input  logic [WORD_W-1:0] tbl_hi,
  input  logic              apply_all,
  output logic [HASH_W-1:0] idx,
  output logic              hit
);
  logic [TBL_N-1:0] table_bits;
  logic             eligible;
  assign table_bits = {tbl_hi, tbl_lo};
  assign idx        = rxf_fold(addr);
  assign eligible   = apply_all || addr[0];
  assign hit        = eligible && table_bits[idx];
endmodule

// File: rtl/rxf_top.sv
module rxf_top
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int WORD_W  = 32,
  parameter int MIN_LEN = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [47:0]       dest_addr,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [3:0]        rx_ctrl,
  input  logic [WORD_W-1:0] ia0_lo,
  input  logic [WORD_W-1:0] ia0_hi,
  input  logic [WORD_W-1:0] ia1_lo,
  input  logic [WORD_W-1:0] ia1_hi,
  input  logic [WORD_W-1:0] grp_lo,
  input  logic [WORD_W-1:0] grp_hi,
  output logic              dec_valid,
  output logic              dec_accept
);
  localparam int NUM_IA = 2;

  logic [WORD_W-1:0] ia_lo_a [NUM_IA];
  logic [WORD_W-1:0] ia_hi_a [NUM_IA];
  logic [NUM_IA-1:0] ia_hit_v;
  logic [HASH_W-1:0] grp_idx;
  logic              grp_hit;
  logic              bcast_hit;
  logic              short_frame;
  rxf_hits_t         hits;
  logic              accept_now;

  assign ia_lo_a[0] = ia0_lo;
  assign ia_hi_a[0] = ia0_hi;
  assign ia_lo_a[1] = ia1_lo;
  assign ia_hi_a[1] = ia1_hi;

  for (genvar g = 0; g < NUM_IA; g++) begin : g_ia
    rxf_ia_match #(.WORD_W(WORD_W)) u_ia (
      .addr (dest_addr),
      .lo   (ia_lo_a[g]),
      .hi   (ia_hi_a[g]),
      .en   (rx_ctrl[CTL_IA0 + g]),
      .hit  (ia_hit_v[g])
    );
  end

  rxf_grp_lookup #(.WORD_W(WORD_W)) u_grp (
    .addr      (dest_addr),
    .tbl_lo    (grp_lo),
    .tbl_hi    (grp_hi),
    .apply_all (rx_ctrl[CTL_GRP_ALL]),
    .idx       (grp_idx),
    .hit       (grp_hit)
  );

  assign bcast_hit   = rx_ctrl[CTL_BCAST] && (&dest_addr);
  assign short_frame = frame_len < LEN_W'(MIN_LEN);
  assign hits        = '{ia: |ia_hit_v, bcast: bcast_hit, grp: grp_hit};
  assign accept_now  = !short_frame && (|hits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= frame_start;
      dec_accept <= frame_start && accept_now;
    end
  end

  // R2: a pulse follows every strobe, and no pulse appears without one
  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> dec_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(frame_start));
  // R10
  a_r10_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
  // R8
  a_r8_short_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && short_frame) |=> !dec_accept);
  // R5
  a_r5_bcast_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !short_frame && rx_ctrl[CTL_BCAST] && (&dest_addr)) |=> dec_accept);
  // R9
  a_r9_no_hit_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && hits == '0) |=> !dec_accept);
  // R7
  a_r7_unicast_gated: assert property (@(posedge clk) disable iff (!rst_n)
    grp_hit |-> (dest_addr[0] || rx_ctrl[CTL_GRP_ALL]));
endmodule

// File: tb/rxf_top_tb_top.sv
module rxf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [47:0] dest_addr = '0;
  logic [15:0] frame_len = '0;
  logic [3:0]  rx_ctrl = '0;
  logic [31:0] ia0_lo = '0, ia0_hi = '0, ia1_lo = '0, ia1_hi = '0;
  logic [31:0] grp_lo = '0, grp_hi = '0;
  logic        dec_valid, dec_accept;

  int checks = 0;
  int fails  = 0;
  int sent   = 0;
  int pulses = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  rxf_top dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dest_addr(dest_addr),
    .frame_len(frame_len), .rx_ctrl(rx_ctrl), .ia0_lo(ia0_lo), .ia0_hi(ia0_hi),
    .ia1_lo(ia1_lo), .ia1_hi(ia1_hi), .grp_lo(grp_lo), .grp_hi(grp_hi),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  function automatic int bench_idx(input logic [47:0] a);
    int r = 0;
    for (int j = 0; j < 6; j++) begin
      bit b = 0;
      for (int k = j; k < 48; k += 6) b ^= a[k];
      if (b) r += (1 << j);
    end
    return r;
  endfunction

  function automatic bit model(input logic [47:0] a, input int len);
    bit keep = 0;
    int ix;
    bit tbit;
    if (len < 12) return 0;
    if (rx_ctrl[0] && a == {ia0_hi[15:0], ia0_lo}) keep = 1;
    if (rx_ctrl[1] && a == {ia1_hi[15:0], ia1_lo}) keep = 1;
    if (rx_ctrl[3] && a == 48'hFFFF_FFFF_FFFF) keep = 1;
    ix = bench_idx(a);
    tbit = (ix < 32) ? grp_lo[ix] : grp_hi[ix - 32];
    if ((a[0] || rx_ctrl[2]) && tbit) keep = 1;
    return keep;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] a, input int len, input string tag);
    @(negedge clk);
    dest_addr = a;
    frame_len = 16'(len);
    frame_start = 1'b1;
    exp_q.push_back(model(a, len));
    tag_q.push_back(tag);
    sent++;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (dec_valid) begin
        pulses++;
        if (exp_q.size() == 0) check("R2 unexpected valid", 1'b1, 1'b0);
        else check(tag_q.pop_front(), dec_accept, exp_q.pop_front());
      end else if (dec_accept) begin
        check("R10 accept without valid", dec_accept, 1'b0);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    ia0_lo = 32'h3322_1102; ia0_hi = 32'h0000_5544;
    ia1_lo = 32'h0123_4544; ia1_hi = 32'h0000_ABCD;
    grp_lo = 32'h0000_0002; grp_hi = 32'h0000_0002;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", dec_valid, 1'b0);
    check("R1 reset accept", dec_accept, 1'b0);

    rx_ctrl = 4'b0001;
    send(48'h5544_3322_1102, 64, "R3 station0 match");
    send(48'h5544_3322_1104, 64, "R9 near miss station0");
    send(48'hABCD_0123_4544, 64, "R4 station1 disabled ignored");
    rx_ctrl = 4'b0010;
    send(48'hABCD_0123_4544, 64, "R4 station1 match");
    send(48'h5544_3322_1102, 64, "R4 station0 disabled ignored");
    send(48'hFFFF_FFFF_FFFF, 64, "R5 bcast disabled");
    rx_ctrl = 4'b1000;
    send(48'hFFFF_FFFF_FFFF, 64, "R5 bcast accepted");
    send(48'hFFFF_FFFF_FFFF, 11, "R8 short bcast dropped");
    send(48'hFFFF_FFFF_FFFF, 12, "R8 length 12 kept");
    rx_ctrl = 4'b0000;
    send(48'h0000_0000_0001, 64, "R6 group low half idx1");
    send(48'h0000_0000_0021, 64, "R6 group high half idx33");
    send(48'h0000_0000_0003, 64, "R6 group idx3 miss");
    send(48'h8000_0000_0000, 64, "R9 unicast idx32 miss");
    send(48'h0000_0000_0040, 64, "R7 unicast hash hit gated");
    rx_ctrl = 4'b0100;
    send(48'h0000_0000_0040, 64, "R7 unicast hash hit applied");
    send(48'h0000_0000_0001, 5,  "R8 short group dropped");
    rx_ctrl = 4'b1011;
    send(48'h1234_5678_9ABC, 64, "R9 all enabled no hit");
    // back-to-back strobes
    @(negedge clk);
    dest_addr = 48'h5544_3322_1102; frame_len = 16'd64; frame_start = 1'b1;
    exp_q.push_back(model(dest_addr, 64)); tag_q.push_back("R2 back-to-back first"); sent++;
    @(negedge clk);
    dest_addr = 48'h0000_0000_0002;
    exp_q.push_back(model(dest_addr, 64)); tag_q.push_back("R2 back-to-back second"); sent++;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 pulse count equals strobes", 1'b1, pulses == sent);
    check("R2 no pending decision", 1'b1, exp_q.size() == 0);
    finish_run();
  end
endmodule